// File: doc/BRIEF.md
# Write-Masked Clock Enable Bank

This block holds a small bank of 16-bit clock-enable words behind a plain 32-bit register port, and turns selected enable bits into gated clocks. Every write carries its own bit mask in the upper half of the data word. Only the enable bits whose mask bit is set take the new value, so software can turn one clock on or off without first reading the word back.

Each gated clock output is tied, at elaboration, to one enable bit by an 8-bit gate code. The upper nibble of the code picks the enable word and the lower nibble picks the bit inside it. The same elaboration table also picks, for each output, whether it is derived from the system clock or from an external reference clock. Each output passes through a latch-based gate that takes a new enable value only while its source clock is low, so a gated output gives whole clock pulses or nothing.

Top module: `clk_gate_bank`

## Requirements
- R1: On a write to an implemented word, bit k (k = 0..15) of the word takes `wdata[k]` when `wdata[k+16]` is 1.
- R2: On a write, bits whose mask bit `wdata[k+16]` is 0 keep their value. With no write strobe, no word changes.
- R3: The word index is `addr[5:2]` (byte addressing, 4-byte stride), so `addr[1:0]` has no effect. Words 0 to 9 are implemented.
- R4: After reset, words 0..9 hold 16'h67ef, 16'h03ff, 16'hff03, 16'hfff0, 16'h0004, 16'h0000, 16'h8000, 16'hffff, 16'h0040, 16'h0000 respectively.
- R5: Reset is synchronous and active low. Asserting it at any time restores every word to its R4 value at the next clock edge.
- R6: `rdata` is combinational from `addr`. It gives zero in bits 31:16 and the addressed word in bits 15:0.
- R7: Word indices 10 to 15 read as zero, and writes to them change no word.
- R8: Gate g follows enable word `GATE_CODE[g][7:4]`, bit `GATE_CODE[g][3:0]`. It pulses while that bit is 1 and stays low while it is 0.
- R9: Gate g is derived from `ref_clk` when `GATE_ON_REF[g]` is 1 and from `clk` otherwise. It gives one pulse per source period while enabled.
- R10: No gated output pulse is shorter than a full high phase of its source clock, even when the enable changes while the clocks run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; clocks the register bank and sources system gates |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | External reference clock for reference-sourced gates |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Byte address of the enable word |
| wdata | input | 32 | Write mask in bits 31:16, write value in bits 15:0 |
| rdata | output | 32 | Addressed enable word, zero-extended |
| gclk | output | NUM_GATES | Gated clock outputs |

## Verification
The table of writes tries a partial mask, a full mask, an empty mask, a mask that only clears bits, an address with nonzero low bits and an out-of-range word. Checking the whole bank after each write tells a wrong mask polarity apart from a wrong word decode or a write that leaks into other words. The gate outputs are counted over fixed windows in the reset state and again after every gate has been flipped. This tells the nibble split of the gate code, the per-gate source choice (pulse rate) and the enable polarity apart. A width monitor on every output looks for pulses shorter than a source high phase.

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
  parameter int NUM_WORDS = 10,
  parameter int ADDR_W    = 6,
  parameter int NUM_GATES = 6,
  parameter logic [NUM_WORDS-1:0][15:0] RESET_VAL = {
    16'h0000, 16'h0040, 16'hffff, 16'h8000, 16'h0000,
    16'h0004, 16'hfff0, 16'hff03, 16'h03ff, 16'h67ef},
  parameter logic [NUM_GATES-1:0][7:0] GATE_CODE = {
    8'h91, 8'h4a, 8'h2f, 8'h13, 8'h05, 8'h00},
  parameter logic [NUM_GATES-1:0] GATE_ON_REF = 6'b010010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_clk,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_GATES-1:0] gclk
);

  localparam int IDX_W = ADDR_W - 2;

  logic [NUM_WORDS-1:0][15:0] en_q;
  logic [IDX_W-1:0]           idx;
  logic                       hit;
  logic [15:0]                mask, val;

  assign idx  = addr[ADDR_W-1:2];
  assign hit  = {1'b0, idx} < (IDX_W+1)'(NUM_WORDS);
  assign mask = wdata[31:16];
  assign val  = wdata[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= RESET_VAL;
    end else if (wr_en && hit) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (idx == IDX_W'(w))
          en_q[w] <= (en_q[w] & ~mask) | (val & mask);
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (hit && idx == IDX_W'(w))
        rdata[15:0] = en_q[w];
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    localparam int WSEL = int'(GATE_CODE[g][7:4]);
    localparam int BSEL = int'(GATE_CODE[g][3:0]);
    logic en, src, en_lat;

    if (WSEL < NUM_WORDS) begin : g_en
      assign en = en_q[WSEL][BSEL];
    end else begin : g_off
      assign en = 1'b0;
    end

    if (GATE_ON_REF[g]) begin : g_ref
      assign src = ref_clk;
    end else begin : g_sys
      assign src = clk;
    end

    always_latch begin
      if (!src) en_lat = en;
    end

    assign gclk[g] = src & en_lat;
  end

endmodule

module clk_gate_bank_chk #(
  parameter int NUM_WORDS = 10,
  parameter int ADDR_W    = 6,
  parameter logic [NUM_WORDS-1:0][15:0] RESET_VAL = '0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          addr,
  input logic [31:0]                wdata,
  input logic [31:0]                rdata,
  input logic [NUM_WORDS-1:0][15:0] words
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] ci;
  logic             in_rng;
  logic [IDX_W-1:0] ci_clip;
  logic [15:0]      want;
  logic             rst_low_q = 1'b0;

  assign ci      = addr[ADDR_W-1:2];
  assign in_rng  = int'(ci) < NUM_WORDS;
  assign ci_clip = in_rng ? ci : '0;
  assign want    = (words[ci_clip] & ~wdata[31:16]) | (wdata[15:0] & wdata[31:16]);

  always @(posedge clk) rst_low_q <= !rst_n;

  assert_masked_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && in_rng |=> words[$past(ci_clip)] == $past(want));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(words));

  assert_reset_values_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_low_q |-> words == RESET_VAL);

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[31:16] == 16'h0000);

  assert_range_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rng |-> rdata == 32'h0);

  assert_range_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !in_rng |=> $stable(words));
endmodule

bind clk_gate_bank clk_gate_bank_chk #(
  .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .RESET_VAL(RESET_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .words(en_q)
);

// File: tb/clk_gate_bank_bench.sv
module clk_gate_bank_bench;
  localparam int NG = 6;
  localparam logic [NG-1:0][7:0] CODES = {8'h91, 8'h4a, 8'h2f, 8'h13, 8'h05, 8'h00};
  localparam logic [NG-1:0]      ONREF = 6'b010010;
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {6'h00, 32'h00ff_1234}, {6'h04, 32'hffff_abcd}, {6'h08, 32'h0000_ffff},
    {6'h0c, 32'h8001_0000}, {6'h11, 32'h0f0f_ffff}, {6'h24, 32'hf000_a5a5},
    {6'h1a, 32'h5555_ffff}, {6'h3c, 32'hffff_ffff}};

  logic clk = 0, ref_clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NG-1:0] gclk;

  int checks = 0, fails = 0, runts = 0;
  int cnt [NG];
  realtime rise_t [NG];
  logic [NG-1:0] prev = '0;
  logic [15:0] m [10];
  bit done = 0;

  always #2.5 clk = ~clk;
  always #3.5 ref_clk = ~ref_clk;

  clk_gate_bank #(.GATE_CODE(CODES), .GATE_ON_REF(ONREF)) u_clk_gate_bank (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .gclk(gclk));

  initial for (int g = 0; g < NG; g++) begin cnt[g] = 0; rise_t[g] = 0; end

  always @(gclk) begin
    for (int g = 0; g < NG; g++) begin
      if (gclk[g] === 1'b1 && prev[g] !== 1'b1) begin
        cnt[g]++; rise_t[g] = $realtime;
      end else if (gclk[g] === 1'b0 && prev[g] === 1'b1) begin
        if ($realtime - rise_t[g] < 2.4) runts++;
      end
    end
    prev = gclk;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m = '{16'h67ef, 16'h03ff, 16'hff03, 16'hfff0, 16'h0004,
          16'h0000, 16'h8000, 16'hffff, 16'h0040, 16'h0000};
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a[5:2] < 10) m[a[5:2]] = (m[a[5:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] q);
    addr = a; #1; q = rdata;
  endtask

  task automatic check_bank(string req);
    logic [31:0] q;
    for (int w = 0; w < 16; w++) begin
      rd(6'(w * 4), q);
      chk(req, q, w < 10 ? {16'h0, m[w]} : 32'h0);
    end
  endtask

  task automatic check_gates(string req);
    int c0 [NG];
    @(negedge clk); repeat (4) @(negedge clk);
    for (int g = 0; g < NG; g++) c0[g] = cnt[g];
    repeat (40) @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      int n = cnt[g] - c0[g];
      bit on = m[CODES[g][7:4]][CODES[g][3:0]];
      bit ok;
      if (!on) ok = (n == 0) && (gclk[g] === 1'b0);
      else if (ONREF[g]) ok = (n >= 27 && n <= 30);
      else ok = (n >= 39 && n <= 41);
      checks++;
      if (!ok) begin
        fails++;
        $display("FAIL %s gate %0d: actual %0d pulses expected %s", req, g, n,
                 !on ? "0" : (ONREF[g] ? "~28" : "~40"));
      end
    end
  endtask

  initial begin
    logic [31:0] q;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_bank("R4");
    check_gates("R8 R9 reset state");

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][37:32], VEC[i][31:0]);
      rd({VEC[i][37:34], 2'b00}, q);
      chk("R1 R2 R3 R7 table", q, VEC[i][37:34] < 10 ? {16'h0, m[VEC[i][37:34]]} : 32'h0);
    end
    check_bank("R2 R6 R7 after table");

    model_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    check_bank("R5 mid-run reset");

    for (int g = 0; g < NG; g++) begin
      logic [3:0] w = CODES[g][7:4];
      logic [3:0] b = CODES[g][3:0];
      if (w < 10) begin
        logic [15:0] bit_m = 16'h1 << b;
        wr({w, 2'b00}, {bit_m, m[w] ^ bit_m});
      end
    end
    check_gates("R8 R1 flipped enables");

    checks++;
    if (runts != 0) begin
      fails++;
      $display("FAIL R10: actual %0d short pulses expected 0", runts);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #500us;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule